// File: doc/BRIEF.md
# USB dual-role clock-reset manager

This block controls the clocks and resets of a USB dual-role subsystem made of three parts: an on-the-go state engine, a device controller and a host controller. The three share a single 48 MHz functional clock (`fclk`). Software reaches two small configuration registers through a request port on an always-on bus clock (`bclk`). The first configuration register holds a self-clearing soft-reset bit, a device-idle bit and a reset-done status bit. The second holds an on-the-go enable bit.

The block also acts as the access gate for the registers of the three controllers. Accesses that are allowed appear as a one-hot forward select. Accesses that are not allowed complete at once with an error flag and zero read data, so the bus never stalls. Whether an access is allowed depends on whether the functional clock is running and on the device-idle state. The block sees the functional clock through a heartbeat that is synchronised into the bus domain.

While the device controller's clock is stopped, the block watches the USB line state with a level detector in the bus domain. When it sees resume signalling it raises a one-cycle wake interrupt. The protocol engines, the SRP/HNP sequences and the PHY are outside this block. It reaches them only through the enable and reset pins.

Top module: `usbdr_clkrst`

## Requirements
- R1: Writing 1 to bit 0 of the first config register (target 0) drives `otg_rst`, `dev_rst` and `host_rst` high together for exactly SR_CYCLES (16) `fclk` cycles.
- R2: In the first config register, bit 0 reads 1 from the soft-reset write until the reset has finished and then reads 0. Bit 2 (reset done) reads 0 after a new soft-reset write and reads 1 once the reset has finished.
- R3: When bit 1 (device idle) of the first config register is 1, `dev_clk_en` is low. When it is 0, `dev_clk_en` is high.
- R4: While device idle is set, device-register reads (target 3) are forwarded (`fwd_sel` = 3'b010). Device-register writes are refused with `rsp_err`.
- R5: While the device clock is stopped, a line state equal to the resume K state (2'b10) gives exactly one `dev_wake_irq` pulse one cycle wide. The device clock counts as stopped when device idle is set or when `fclk` is inactive. While the device is clocked, the K state gives no pulse.
- R6: `fclk` counts as inactive after ALIVE_WIN (8) bus cycles with no heartbeat edge. While it is inactive, host-register accesses (target 4) and device-register reads are refused.
- R7: Bit 0 of the second config register (target 1) drives `otg_clk_en`: 0 stops the on-the-go clock, 1 runs it.
- R8: The first config register can be read and written while `fclk` is inactive. The second config register and the on-the-go control register (target 2) are refused while `fclk` is inactive.
- R9: While `hw_rst_n` is low, all clock enables are low and all three resets are high. After reset, both config registers read 0.
- R10: A refused access returns `rsp_err` = 1, `rsp_rdata` = 0 and `fwd_sel` = 0. An allowed access to a controller target sets one bit of `fwd_sel`: bit 0 for on-the-go control, bit 1 for device, bit 2 for host.
- R11: `rsp_valid` rises exactly one `bclk` cycle after `req_valid` and stays high for that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Always-on bus clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| req_valid | input | 1 | Register access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tgt | input | 3 | Target: 0 cfg1, 1 cfg2, 2 otg ctrl, 3 device, 4 host |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | DW | Read data for config registers, otherwise 0 |
| fwd_sel | output | 3 | One-hot forward select {host, device, otg ctrl} |
| dev_wake_irq | output | 1 | Resume wake interrupt pulse |
| fclk | input | 1 | Shared 48 MHz functional clock |
| line_state | input | 2 | USB line state, asynchronous |
| otg_clk_en | output | 1 | On-the-go engine clock enable |
| dev_clk_en | output | 1 | Device controller clock enable |
| host_clk_en | output | 1 | Host controller clock enable |
| otg_rst | output | 1 | On-the-go engine reset |
| dev_rst | output | 1 | Device controller reset |
| host_rst | output | 1 | Host controller reset |

## Verification
Access responses are due exactly one `bclk` edge after the request. The bench drives requests at a falling edge and samples the response at the next falling edge. Results that cross a clock domain are checked differently because their arrival depends on the phase between the two clocks. These are the clock enables, the clock-activity verdict and soft-reset completion. For each of them the bench waits a fixed settle time longer than the synchroniser depth plus the ALIVE_WIN window, or polls with a bounded limit. The wake pulse needs two synchroniser stages and one output register, so it is due three edges after the line change. The bench waits a few cycles for it, and then counts pulses over a window to confirm the single-cycle width. The length of the soft-reset pulse is measured in `fclk` cycles by a counter in the bench.

// File: rtl/usbdr_pkg.sv
package usbdr_pkg;
  typedef enum logic [2:0] {
    TGT_CFG1   = 3'd0,
    TGT_CFG2   = 3'd1,
    TGT_OTGCTL = 3'd2,
    TGT_DEV    = 3'd3,
    TGT_HOST   = 3'd4
  } tgt_e;

  localparam int CFG1_SRST_BIT  = 0;
  localparam int CFG1_IDLE_BIT  = 1;
  localparam int CFG1_DONE_BIT  = 2;
  localparam int CFG2_OTGEN_BIT = 0;

  localparam int FWD_OTGCTL = 0;
  localparam int FWD_DEV    = 1;
  localparam int FWD_HOST   = 2;
endpackage

// File: rtl/usbdr_sync.sv
module usbdr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/usbdr_fclk_ctl.sv
module usbdr_fclk_ctl #(
  parameter int SR_CYCLES = 16
) (
  input  logic fclk,
  input  logic hw_rst_n,
  input  logic sr_req_tgl,
  input  logic dev_idle,
  input  logic otg_en,
  output logic hb_tgl,
  output logic sr_done_tgl,
  output logic otg_clk_en,
  output logic dev_clk_en,
  output logic host_clk_en,
  output logic otg_rst,
  output logic dev_rst,
  output logic host_rst
);
  localparam int CW = $clog2(SR_CYCLES + 1);

  logic [1:0]    rst_chain;
  logic          frst_n;
  logic [2:0]    ctl_s;
  logic          req_s, idle_s, otg_s;
  logic          req_seen;
  logic [CW-1:0] sr_cnt;
  logic          srst;

  // reset synchroniser: asynchronous assert, synchronous release
  always_ff @(posedge fclk or negedge hw_rst_n) begin
    if (!hw_rst_n) rst_chain <= '0;
    else           rst_chain <= {rst_chain[0], 1'b1};
  end
  assign frst_n = rst_chain[1];

  usbdr_sync #(.W(3), .STAGES(2)) u_ctl_sync (
    .clk  (fclk),
    .rst_n(frst_n),
    .d    ({sr_req_tgl, dev_idle, otg_en}),
    .q    (ctl_s)
  );
  assign {req_s, idle_s, otg_s} = ctl_s;

  // heartbeat seen by the bus-side activity monitor
  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) hb_tgl <= 1'b0;
    else         hb_tgl <= ~hb_tgl;
  end

  // soft-reset sequencer
  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      req_seen    <= 1'b0;
      sr_cnt      <= '0;
      sr_done_tgl <= 1'b0;
    end else if (req_s != req_seen) begin
      req_seen <= req_s;
      sr_cnt   <= CW'(SR_CYCLES);
    end else if (sr_cnt != '0) begin
      sr_cnt <= sr_cnt - 1'b1;
      if (sr_cnt == CW'(1)) sr_done_tgl <= ~sr_done_tgl;
    end
  end
  assign srst = (sr_cnt != '0);

  assign otg_rst     = ~frst_n | srst;
  assign dev_rst     = ~frst_n | srst;
  assign host_rst    = ~frst_n | srst;
  assign host_clk_en = frst_n;
  assign dev_clk_en  = frst_n & ~idle_s;
  assign otg_clk_en  = frst_n & otg_s;
endmodule

// File: rtl/usbdr_wake.sv
module usbdr_wake #(
  parameter int         ALIVE_WIN = 8,
  parameter logic [1:0] K_STATE   = 2'b10
) (
  input  logic       bclk,
  input  logic       rst_n,
  input  logic       hb_tgl,
  input  logic [1:0] line_state,
  input  logic       dev_idle,
  output logic       fclk_alive,
  output logic       wake_irq
);
  localparam int CW = $clog2(ALIVE_WIN + 1);

  logic          hb_s, hb_d;
  logic [CW-1:0] quiet_cnt;
  logic [1:0]    ls_s;
  logic          wake_lvl, wake_d;

  usbdr_sync #(.W(1), .STAGES(2)) u_hb_sync (
    .clk(bclk), .rst_n(rst_n), .d(hb_tgl), .q(hb_s)
  );
  usbdr_sync #(.W(2), .STAGES(2)) u_ls_sync (
    .clk(bclk), .rst_n(rst_n), .d(line_state), .q(ls_s)
  );

  // activity monitor: clock counts as alive while heartbeat edges keep arriving
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hb_d      <= 1'b0;
      quiet_cnt <= CW'(ALIVE_WIN);
    end else begin
      hb_d <= hb_s;
      if (hb_s != hb_d)                  quiet_cnt <= '0;
      else if (quiet_cnt != CW'(ALIVE_WIN)) quiet_cnt <= quiet_cnt + 1'b1;
    end
  end
  assign fclk_alive = (quiet_cnt != CW'(ALIVE_WIN));

  // resume level detect while the device clock is stopped
  assign wake_lvl = (dev_idle | ~fclk_alive) & (ls_s == K_STATE);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      wake_d   <= 1'b0;
      wake_irq <= 1'b0;
    end else begin
      wake_d   <= wake_lvl;
      wake_irq <= wake_lvl & ~wake_d;
    end
  end
endmodule

// File: rtl/usbdr_regs.sv
module usbdr_regs
  import usbdr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2:0]    req_tgt,
  input  logic [DW-1:0] req_wdata,
  input  logic          fclk_alive,
  input  logic          sr_done_tgl,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [2:0]    fwd_sel,
  output logic          sr_req_tgl,
  output logic          dev_idle,
  output logic          otg_en
);
  logic          done_s, done_d;
  logic          sr_busy, sr_done;
  logic          allow;
  logic [2:0]    fwd_next;
  logic [DW-1:0] rd_next;

  usbdr_sync #(.W(1), .STAGES(2)) u_done_sync (
    .clk(bclk), .rst_n(rst_n), .d(sr_done_tgl), .q(done_s)
  );

  always_comb begin
    allow    = 1'b0;
    fwd_next = '0;
    rd_next  = '0;
    case (req_tgt)
      TGT_CFG1: begin
        allow = 1'b1;
        rd_next[CFG1_SRST_BIT] = sr_busy;
        rd_next[CFG1_IDLE_BIT] = dev_idle;
        rd_next[CFG1_DONE_BIT] = sr_done;
      end
      TGT_CFG2: begin
        allow = fclk_alive;
        rd_next[CFG2_OTGEN_BIT] = otg_en;
      end
      TGT_OTGCTL: begin
        allow = fclk_alive;
        fwd_next[FWD_OTGCTL] = fclk_alive;
      end
      TGT_DEV: begin
        allow = fclk_alive & (~req_write | ~dev_idle);
        fwd_next[FWD_DEV] = fclk_alive & (~req_write | ~dev_idle);
      end
      TGT_HOST: begin
        allow = fclk_alive;
        fwd_next[FWD_HOST] = fclk_alive;
      end
      default: allow = 1'b0;
    endcase
  end

  // config state
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      done_d     <= 1'b0;
      sr_busy    <= 1'b0;
      sr_done    <= 1'b0;
      sr_req_tgl <= 1'b0;
      dev_idle   <= 1'b0;
      otg_en     <= 1'b0;
    end else begin
      done_d <= done_s;
      if (done_s != done_d) begin
        sr_busy <= 1'b0;
        sr_done <= 1'b1;
      end
      if (req_valid && req_write && allow) begin
        if (req_tgt == TGT_CFG1) begin
          dev_idle <= req_wdata[CFG1_IDLE_BIT];
          if (req_wdata[CFG1_SRST_BIT] && !sr_busy) begin
            sr_busy    <= 1'b1;
            sr_done    <= 1'b0;
            sr_req_tgl <= ~sr_req_tgl;
          end
        end
        if (req_tgt == TGT_CFG2) otg_en <= req_wdata[CFG2_OTGEN_BIT];
      end
    end
  end

  // response, one cycle after the request
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      fwd_sel   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & ~allow;
      rsp_rdata <= (req_valid && allow && !req_write) ? rd_next : '0;
      fwd_sel   <= req_valid ? fwd_next : 3'b000;
    end
  end
endmodule

// File: rtl/usbdr_clkrst.sv
module usbdr_clkrst #(
  parameter int         DW        = 8,
  parameter int         SR_CYCLES = 16,
  parameter int         ALIVE_WIN = 8,
  parameter logic [1:0] K_STATE   = 2'b10
) (
  input  logic          bclk,
  input  logic          hw_rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2:0]    req_tgt,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [2:0]    fwd_sel,
  output logic          dev_wake_irq,
  input  logic          fclk,
  input  logic [1:0]    line_state,
  output logic          otg_clk_en,
  output logic          dev_clk_en,
  output logic          host_clk_en,
  output logic          otg_rst,
  output logic          dev_rst,
  output logic          host_rst
);
  logic fclk_alive;
  logic sr_done_tgl;
  logic sr_req_tgl;
  logic dev_idle;
  logic otg_en;
  logic hb_tgl;

  usbdr_regs #(.DW(DW)) u_regs (
    .bclk       (bclk),
    .rst_n      (hw_rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_tgt    (req_tgt),
    .req_wdata  (req_wdata),
    .fclk_alive (fclk_alive),
    .sr_done_tgl(sr_done_tgl),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .fwd_sel    (fwd_sel),
    .sr_req_tgl (sr_req_tgl),
    .dev_idle   (dev_idle),
    .otg_en     (otg_en)
  );

  usbdr_wake #(.ALIVE_WIN(ALIVE_WIN), .K_STATE(K_STATE)) u_wake (
    .bclk      (bclk),
    .rst_n     (hw_rst_n),
    .hb_tgl    (hb_tgl),
    .line_state(line_state),
    .dev_idle  (dev_idle),
    .fclk_alive(fclk_alive),
    .wake_irq  (dev_wake_irq)
  );

  usbdr_fclk_ctl #(.SR_CYCLES(SR_CYCLES)) u_fclk (
    .fclk       (fclk),
    .hw_rst_n   (hw_rst_n),
    .sr_req_tgl (sr_req_tgl),
    .dev_idle   (dev_idle),
    .otg_en     (otg_en),
    .hb_tgl     (hb_tgl),
    .sr_done_tgl(sr_done_tgl),
    .otg_clk_en (otg_clk_en),
    .dev_clk_en (dev_clk_en),
    .host_clk_en(host_clk_en),
    .otg_rst    (otg_rst),
    .dev_rst    (dev_rst),
    .host_rst   (host_rst)
  );
endmodule

// File: rtl/usbdr_clkrst_chk.sv
module usbdr_clkrst_chk (
  input logic       bclk,
  input logic       hw_rst_n,
  input logic       req_valid,
  input logic       req_write,
  input logic [2:0] req_tgt,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic [7:0] rsp_rdata,
  input logic [2:0] fwd_sel,
  input logic       dev_wake_irq,
  input logic       dev_idle,
  input logic       fclk_alive
);
  p_rsp_latency_r11: assert property (@(posedge bclk) disable iff (!hw_rst_n)
    req_valid |=> rsp_valid);

  p_rsp_single_r11: assert property (@(posedge bclk) disable iff (!hw_rst_n)
    !req_valid |=> !rsp_valid);

  p_err_zero_data_r10: assert property (@(posedge bclk) disable iff (!hw_rst_n)
    rsp_err |-> (rsp_rdata == 8'd0 && fwd_sel == 3'b000));

  p_fwd_onehot_r10: assert property (@(posedge bclk) disable iff (!hw_rst_n)
    $onehot0(fwd_sel));

  p_idle_write_blocked_r4: assert property (@(posedge bclk) disable iff (!hw_rst_n)
    (req_valid && req_write && req_tgt == 3'd3 && dev_idle) |=> rsp_err);

  p_cfg1_open_r8: assert property (@(posedge bclk) disable iff (!hw_rst_n)
    (req_valid && req_tgt == 3'd0) |=> !rsp_err);

  p_host_needs_clk_r6: assert property (@(posedge bclk) disable iff (!hw_rst_n)
    (req_valid && req_tgt == 3'd4 && !fclk_alive) |=> rsp_err);

  p_wake_pulse_r5: assert property (@(posedge bclk) disable iff (!hw_rst_n)
    dev_wake_irq |=> !dev_wake_irq);
endmodule

bind usbdr_clkrst usbdr_clkrst_chk u_chk (
  .bclk        (bclk),
  .hw_rst_n    (hw_rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_tgt     (req_tgt),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .rsp_rdata   (rsp_rdata),
  .fwd_sel     (fwd_sel),
  .dev_wake_irq(dev_wake_irq),
  .dev_idle    (dev_idle),
  .fclk_alive  (fclk_alive)
);

// File: tb/usbdr_clkrst_bench.sv
`timescale 1ns/1ps
module usbdr_clkrst_bench;
  logic       bclk = 1'b0;
  logic       fclk = 1'b0;
  logic       fclk_run = 1'b1;
  logic       hw_rst_n = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [2:0] req_tgt = 3'd0;
  logic [7:0] req_wdata = 8'd0;
  logic [1:0] line_state = 2'b01;
  logic       rsp_valid, rsp_err, dev_wake_irq;
  logic [7:0] rsp_rdata;
  logic [2:0] fwd_sel;
  logic       otg_clk_en, dev_clk_en, host_clk_en, otg_rst, dev_rst, host_rst;

  int n_tests = 0;
  int n_fail  = 0;
  int srst_cycles = 0;
  int srst_mismatch = 0;
  logic       got_valid, got_err;
  logic [7:0] got_data;
  logic [2:0] got_fwd;

  always #10 bclk = ~bclk;
  always #10.417 if (fclk_run) fclk = ~fclk;

  always @(posedge fclk) begin
    if (hw_rst_n) begin
      if (dev_rst) srst_cycles++;
      if ((otg_rst != dev_rst) || (host_rst != dev_rst)) srst_mismatch++;
    end
  end

  usbdr_clkrst u_usbdr_clkrst (
    .bclk(bclk), .hw_rst_n(hw_rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_tgt(req_tgt), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .fwd_sel(fwd_sel), .dev_wake_irq(dev_wake_irq), .fclk(fclk),
    .line_state(line_state), .otg_clk_en(otg_clk_en), .dev_clk_en(dev_clk_en),
    .host_clk_en(host_clk_en), .otg_rst(otg_rst), .dev_rst(dev_rst), .host_rst(host_rst)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge bclk);
  endtask

  task automatic access(input logic [2:0] tgt, input logic wr, input logic [7:0] data);
    @(negedge bclk);
    req_valid = 1'b1; req_write = wr; req_tgt = tgt; req_wdata = data;
    @(negedge bclk);
    got_valid = rsp_valid; got_err = rsp_err; got_data = rsp_rdata; got_fwd = fwd_sel;
    req_valid = 1'b0; req_write = 1'b0; req_wdata = 8'd0;
  endtask

  task automatic count_irq(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge bclk);
      if (dev_wake_irq) cnt++;
    end
  endtask

  task automatic t_reset;
    #2 hw_rst_n = 1'b0;
    #100;
    check(!otg_clk_en && !dev_clk_en && !host_clk_en, "R9 enables low in reset",
          {otg_clk_en, dev_clk_en, host_clk_en}, 0);
    check(otg_rst && dev_rst && host_rst, "R9 resets high in reset",
          {otg_rst, dev_rst, host_rst}, 7);
    @(negedge bclk) hw_rst_n = 1'b1;
    wait_cyc(20);
    check(host_clk_en && dev_clk_en && !otg_clk_en, "R9 enables after reset",
          {otg_clk_en, dev_clk_en, host_clk_en}, 3);
    access(3'd0, 1'b0, 8'd0);
    check(got_data == 8'd0 && !got_err, "R9 cfg1 reset value", got_data, 0);
    access(3'd1, 1'b0, 8'd0);
    check(got_data == 8'd0 && !got_err, "R9 cfg2 reset value", got_data, 0);
  endtask

  task automatic t_latency;
    @(negedge bclk);
    req_valid = 1'b1; req_tgt = 3'd0;
    #1 check(!rsp_valid, "R11 no response before edge", rsp_valid, 0);
    @(negedge bclk);
    check(rsp_valid, "R11 response one cycle later", rsp_valid, 1);
    req_valid = 1'b0;
    @(negedge bclk);
    check(!rsp_valid, "R11 response lasts one cycle", rsp_valid, 0);
  endtask

  task automatic t_softreset;
    int polls;
    srst_cycles = 0; srst_mismatch = 0;
    access(3'd0, 1'b1, 8'h01);
    access(3'd0, 1'b0, 8'd0);
    check(got_data[0] == 1'b1 && got_data[2] == 1'b0, "R2 busy set done clear",
          got_data, 1);
    polls = 0;
    while (got_data[0] && polls < 200) begin
      access(3'd0, 1'b0, 8'd0);
      polls++;
    end
    check(got_data[0] == 1'b0, "R2 soft-reset bit self clears", got_data[0], 0);
    check(got_data[2] == 1'b1, "R2 reset-done set", got_data[2], 1);
    check(srst_cycles == 16, "R1 soft reset length", srst_cycles, 16);
    check(srst_mismatch == 0, "R1 three resets together", srst_mismatch, 0);
    access(3'd0, 1'b1, 8'h01);
    access(3'd0, 1'b0, 8'd0);
    check(got_data[2] == 1'b0, "R2 reset-done cleared by new write", got_data[2], 0);
    wait_cyc(40);
  endtask

  task automatic t_idle;
    access(3'd0, 1'b1, 8'h02);
    wait_cyc(6);
    check(!dev_clk_en, "R3 idle stops device clock", dev_clk_en, 0);
    access(3'd3, 1'b0, 8'd0);
    check(!got_err && got_fwd == 3'b010, "R4 device read while idle", got_fwd, 2);
    access(3'd3, 1'b1, 8'h55);
    check(got_err && got_fwd == 3'b000, "R4 device write blocked", got_err, 1);
    check(got_data == 8'd0, "R10 blocked access data", got_data, 0);
    access(3'd0, 1'b1, 8'h00);
    wait_cyc(6);
    check(dev_clk_en, "R3 device clock back", dev_clk_en, 1);
    access(3'd3, 1'b1, 8'h55);
    check(!got_err && got_fwd == 3'b010, "R4 device write after idle", got_fwd, 2);
    access(3'd2, 1'b0, 8'd0);
    check(!got_err && got_fwd == 3'b001, "R10 otg ctrl forward", got_fwd, 1);
  endtask

  task automatic t_otg;
    access(3'd1, 1'b1, 8'h01);
    wait_cyc(6);
    check(otg_clk_en, "R7 otg enable on", otg_clk_en, 1);
    access(3'd1, 1'b0, 8'd0);
    check(got_data == 8'h01, "R7 cfg2 readback", got_data, 1);
    access(3'd1, 1'b1, 8'h00);
    wait_cyc(6);
    check(!otg_clk_en, "R7 otg enable off", otg_clk_en, 0);
  endtask

  task automatic t_wake;
    int cnt;
    access(3'd0, 1'b1, 8'h02);
    @(negedge bclk) line_state = 2'b10;
    count_irq(10, cnt);
    check(cnt == 1, "R5 wake pulse while idle", cnt, 1);
    line_state = 2'b01;
    access(3'd0, 1'b1, 8'h00);
    wait_cyc(4);
    line_state = 2'b10;
    count_irq(10, cnt);
    check(cnt == 0, "R5 no wake while clocked", cnt, 0);
    line_state = 2'b01;
    wait_cyc(4);
  endtask

  task automatic t_noclk;
    int cnt;
    fclk_run = 1'b0;
    wait_cyc(20);
    access(3'd4, 1'b0, 8'd0);
    check(got_err && got_fwd == 3'b000, "R6 host blocked without clock", got_err, 1);
    access(3'd3, 1'b0, 8'd0);
    check(got_err, "R6 device read blocked without clock", got_err, 1);
    access(3'd1, 1'b0, 8'd0);
    check(got_err && got_data == 8'd0, "R8 cfg2 blocked without clock", got_err, 1);
    access(3'd2, 1'b0, 8'd0);
    check(got_err, "R8 otg ctrl blocked without clock", got_err, 1);
    access(3'd0, 1'b0, 8'd0);
    check(!got_err && got_valid, "R8 cfg1 open without clock", got_err, 0);
    @(negedge bclk) line_state = 2'b10;
    count_irq(10, cnt);
    check(cnt == 1, "R5 wake pulse with clock off", cnt, 1);
    line_state = 2'b01;
    fclk_run = 1'b1;
    wait_cyc(20);
    access(3'd4, 1'b1, 8'h11);
    check(!got_err && got_fwd == 3'b100, "R10 host forward after restart", got_fwd, 4);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_softreset();
    t_idle();
    t_otg();
    t_wake();
    t_noclk();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule